// File: doc/BRIEF.md
# Interval Timer Bus Front End

This block is the processor-facing side of a three-channel interval timer. It watches an 8-bit data bus qualified by an active-low select, active-low read and write strobes and a 2-bit address. Each access becomes a single-cycle strobe for one of three counter channels in the system clock domain. The channel blocks themselves own the counting, the byte ordering and the latch storage. A write may carry data for a channel. A write may also carry a command word, which is split into a per-channel setup (access format, mode, decimal flag), a request to freeze one channel's count, or a broadcast request that freezes count and/or status on any mix of channels.

Reads are served combinationally. The addressed channel's current read byte is steered onto the output, and an enable marks when the external driver should be on. When a read ends, a strobe tells that channel that one byte was taken. The bus is treated as synchronous to the block clock. A write or read is seen once per strobe low period, however long that period is.

Top module: `tmr_bus_front`

## Requirements
- R1: While `rst_n` is low, every strobe output, `wr_byte`, `ctrl_rw`, `ctrl_mode` and `ctrl_bcd` are zero.
- R2: A write with `cs_n` and `wr_n` both low at address 0, 1 or 2 raises `load_stb` bit 0, 1 or 2. The data byte appears on `wr_byte` in the cycle that starts at the clock edge after the first edge that samples the write.
- R3: With `cs_n` high, no strobe is produced and `dout_en` stays low, whatever `rd_n` and `wr_n` do.
- R4: A write at address 3 whose bits 7:6 are not 11 and whose bits 5:4 are not 00 pulses `ctrl_stb` for the channel numbered by bits 7:6. On the same edge it sets `ctrl_rw` from bits 5:4, `ctrl_mode` from bits 3:1 and `ctrl_bcd` from bit 0.
- R5: A mode field with bit 1 set (bits 3:1 = x10 or x11) is presented as 010 or 011. `ctrl_mode` never holds 110 or 111.
- R6: A write at address 3 with bits 5:4 = 00 and bits 7:6 not 11 pulses `cnt_latch_stb` for the channel in bits 7:6. It does not pulse `ctrl_stb` and leaves `ctrl_rw`, `ctrl_mode` and `ctrl_bcd` unchanged.
- R7: A write at address 3 with bits 7:6 = 11 and bit 0 = 0 is a broadcast latch. Bits 1, 2 and 3 select channels 0, 1 and 2. Bit 5 low pulses `cnt_latch_stb` and bit 4 low pulses `sts_latch_stb` on every selected channel.
- R8: A broadcast latch with bit 0 set produces no strobe.
- R9: `dout_en` is high exactly while `cs_n` and `rd_n` are both low. `dout` then equals byte `addr` of `ch_rdata` (bits 8*addr+7 down to 8*addr).
- R10: A read at address 3 drives `dout` = `IDLE_BYTE` (default 8'hFF) and produces no `rd_stb`.
- R11: When a read at address 0 to 2 ends, `rd_stb` for that channel is high in the cycle that starts at the edge after the first edge that samples the read released.
- R12: Each write or read pulse, however many cycles it lasts, yields exactly one strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low select |
| rd_n | input | 1 | Active-low read |
| wr_n | input | 1 | Active-low write |
| addr | input | 2 | Register address |
| din | input | 8 | Write data |
| ch_rdata | input | 24 | Read bytes of channels 2,1,0 (channel 0 in bits 7:0) |
| dout | output | 8 | Read data |
| dout_en | output | 1 | Read data driver enable |
| wr_byte | output | 8 | Byte of the last write |
| load_stb | output | 3 | Per-channel data write strobe |
| ctrl_stb | output | 3 | Per-channel setup strobe |
| ctrl_rw | output | 2 | Access format from the last setup |
| ctrl_mode | output | 3 | Normalised mode from the last setup |
| ctrl_bcd | output | 1 | Decimal flag from the last setup |
| cnt_latch_stb | output | 3 | Per-channel count freeze strobe |
| sts_latch_stb | output | 3 | Per-channel status freeze strobe |
| rd_stb | output | 3 | Per-channel byte-taken strobe |

## Verification
`dout` and `dout_en` are combinational and are due in the same cycle as the bus inputs. Write strobes and setup fields are due one edge after the edge that first samples the write, and read strobes one edge after the edge that first samples the release. The reference model in the bench books each detected bus event at one edge and releases its expected outputs at the next. It compares every output one nanosecond after each rising edge, when both the design and the model have settled. Held strobes and pulse counters are then checked after each access, which covers the single-pulse and no-effect cases.

// File: rtl/tmr_bus_front.sv
module tmr_bus_front #(
  parameter logic [7:0] IDLE_BYTE = 8'hFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_n,
  input  logic        rd_n,
  input  logic        wr_n,
  input  logic [1:0]  addr,
  input  logic [7:0]  din,
  input  logic [23:0] ch_rdata,
  output logic [7:0]  dout,
  output logic        dout_en,
  output logic [7:0]  wr_byte,
  output logic [2:0]  load_stb,
  output logic [2:0]  ctrl_stb,
  output logic [1:0]  ctrl_rw,
  output logic [2:0]  ctrl_mode,
  output logic        ctrl_bcd,
  output logic [2:0]  cnt_latch_stb,
  output logic [2:0]  sts_latch_stb,
  output logic [2:0]  rd_stb
);
  localparam logic [1:0] CMD_ADDR = 2'b11;

  wire wr_now = !cs_n && !wr_n;
  wire rd_now = !cs_n && !rd_n;

  logic       wr_s, wr_p, rd_s, rd_p;
  logic [1:0] wa_s, ra_s;
  logic [7:0] wd_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_s <= 1'b0;
      wr_p <= 1'b0;
      rd_s <= 1'b0;
      rd_p <= 1'b0;
      wa_s <= '0;
      ra_s <= '0;
      wd_s <= '0;
    end else begin
      wr_s <= wr_now;
      wr_p <= wr_s;
      rd_s <= rd_now;
      rd_p <= rd_s;
      if (wr_now) begin
        wa_s <= addr;
        wd_s <= din;
      end
      if (rd_now) ra_s <= addr;
    end
  end

  wire wr_fire = wr_s && !wr_p;
  wire rd_done = !rd_s && rd_p;

  wire       is_cmd = (wa_s == CMD_ADDR);
  wire [1:0] sc     = wd_s[7:6];
  wire [1:0] rl     = wd_s[5:4];
  wire       rb     = (sc == 2'b11);
  wire       rb_ok  = rb && !wd_s[0];
  wire [2:0] sc_hot = 3'b001 << sc;
  wire [2:0] rb_sel = wd_s[3:1];
  wire [2:0] mode_n = wd_s[2] ? {1'b0, wd_s[2:1]} : wd_s[3:1];

  logic [2:0] ld_n, cw_n, cl_n, sl_n, rs_n;

  always_comb begin
    ld_n = '0;
    cw_n = '0;
    cl_n = '0;
    sl_n = '0;
    rs_n = '0;
    if (wr_fire) begin
      if (!is_cmd) ld_n = 3'b001 << wa_s;
      else if (!rb) begin
        if (rl == 2'b00) cl_n = sc_hot;
        else             cw_n = sc_hot;
      end else if (rb_ok) begin
        if (!wd_s[5]) cl_n = rb_sel;
        if (!wd_s[4]) sl_n = rb_sel;
      end
    end
    if (rd_done && ra_s != CMD_ADDR) rs_n = 3'b001 << ra_s;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_stb      <= '0;
      ctrl_stb      <= '0;
      cnt_latch_stb <= '0;
      sts_latch_stb <= '0;
      rd_stb        <= '0;
      wr_byte       <= '0;
      ctrl_rw       <= '0;
      ctrl_mode     <= '0;
      ctrl_bcd      <= 1'b0;
    end else begin
      load_stb      <= ld_n;
      ctrl_stb      <= cw_n;
      cnt_latch_stb <= cl_n;
      sts_latch_stb <= sl_n;
      rd_stb        <= rs_n;
      if (wr_fire) wr_byte <= wd_s;
      if (|cw_n) begin
        ctrl_rw   <= rl;
        ctrl_mode <= mode_n;
        ctrl_bcd  <= wd_s[0];
      end
    end
  end

  assign dout_en = rd_now;
  assign dout    = (addr == CMD_ADDR) ? IDLE_BYTE : ch_rdata[8*addr +: 8];
endmodule

// File: rtl/tmr_bus_front_chk.sv
module tmr_bus_front_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       dout_en,
  input logic [2:0] load_stb,
  input logic [2:0] ctrl_stb,
  input logic [1:0] ctrl_rw,
  input logic [2:0] ctrl_mode,
  input logic       ctrl_bcd,
  input logic [2:0] cnt_latch_stb,
  input logic [2:0] sts_latch_stb,
  input logic [2:0] rd_stb
);
  assert_load_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load_stb));

  assert_load_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (|load_stb) |=> (load_stb == 3'b000));

  assert_rd_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (|rd_stb) |=> (rd_stb == 3'b000));

  assert_rd_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_stb));

  assert_no_drive_unselected_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !dout_en);

  assert_setup_alone_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|ctrl_stb) |-> (load_stb == 3'b000 && sts_latch_stb == 3'b000 && ctrl_rw != 2'b00));

  assert_setup_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ctrl_stb));

  assert_mode_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_mode[2] |-> !ctrl_mode[1]);

  assert_fields_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_stb == 3'b000) |-> $stable({ctrl_rw, ctrl_mode, ctrl_bcd}));

  assert_sts_only_broadcast_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|sts_latch_stb) |-> (ctrl_stb == 3'b000 && load_stb == 3'b000));
endmodule

bind tmr_bus_front tmr_bus_front_chk chk_i (.*);

// File: tb/tmr_bus_front_tb_top.sv
module tmr_bus_front_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0]  addr = 2'd0;
  logic [7:0]  din = 8'd0;
  logic [23:0] ch_rdata = 24'h5A3CA1;
  logic [7:0]  dout, wr_byte;
  logic        dout_en, ctrl_bcd;
  logic [2:0]  load_stb, ctrl_stb, ctrl_mode, cnt_latch_stb, sts_latch_stb, rd_stb;
  logic [1:0]  ctrl_rw;

  int n_chk = 0, n_err = 0, cycles = 0;
  int cnt_ld = 0, cnt_lat = 0, cnt_rd = 0;

  always #2 clk = ~clk;

  tmr_bus_front dut_i (.*);

  task automatic chk(int act, int exp, string tag);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int e_ld, e_cw, e_cl, e_sl, e_rs, e_rw, e_mode, e_bcd, e_wb;
  int pw, pw_a, pw_d, pr, pr_a, m_wprev, m_rprev, m_ra;

  always @(posedge clk) begin
    if (!rst_n) begin
      {e_ld, e_cw, e_cl, e_sl, e_rs, e_rw, e_mode, e_bcd, e_wb} = '{default: 0};
      {pw, pr, m_wprev, m_rprev, m_ra, pw_a, pw_d, pr_a} = '{default: 0};
    end else begin
      e_ld = 0; e_cw = 0; e_cl = 0; e_sl = 0; e_rs = 0;
      if (pw != 0) begin
        e_wb = pw_d;
        if (pw_a != 3) e_ld = 1 << pw_a;
        else begin
          int sc, rl, m;
          sc = pw_d / 64;
          rl = (pw_d / 16) % 4;
          if (sc != 3) begin
            if (rl == 0) e_cl = 1 << sc;
            else begin
              e_cw = 1 << sc;
              e_rw = rl;
              m = (pw_d / 2) % 8;
              if ((m % 4) >= 2) m = m % 4;
              e_mode = m;
              e_bcd = pw_d % 2;
            end
          end else if (pw_d % 2 == 0) begin
            if ((pw_d & 32) == 0) e_cl = (pw_d / 2) % 8;
            if ((pw_d & 16) == 0) e_sl = (pw_d / 2) % 8;
          end
        end
      end
      if (pr != 0 && pr_a != 3) e_rs = 1 << pr_a;
      begin
        int wa, ra;
        wa = (!cs_n && !wr_n) ? 1 : 0;
        ra = (!cs_n && !rd_n) ? 1 : 0;
        pw = (wa == 1 && m_wprev == 0) ? 1 : 0;
        pw_a = addr; pw_d = din;
        pr = (ra == 0 && m_rprev == 1) ? 1 : 0;
        pr_a = m_ra;
        if (ra == 1) m_ra = addr;
        m_wprev = wa; m_rprev = ra;
      end
    end
  end

  always @(posedge clk) begin
    #1;
    cycles++;
    if (|load_stb) cnt_ld++;
    if ((|cnt_latch_stb) || (|sts_latch_stb)) cnt_lat++;
    if (|rd_stb) cnt_rd++;
    if (rst_n) begin
      chk(load_stb, e_ld, "R2 load_stb");
      chk(wr_byte, e_wb, "R2 wr_byte");
      chk(ctrl_stb, e_cw, "R4 ctrl_stb");
      chk(ctrl_rw, e_rw, "R4 ctrl_rw");
      chk(ctrl_bcd, e_bcd, "R4 ctrl_bcd");
      chk(ctrl_mode, e_mode, "R5 ctrl_mode");
      chk(cnt_latch_stb, e_cl, "R6/R7 cnt_latch_stb");
      chk(sts_latch_stb, e_sl, "R7 sts_latch_stb");
      chk(rd_stb, e_rs, "R11 rd_stb");
      chk(dout_en, (!cs_n && !rd_n) ? 1 : 0, "R9 dout_en");
      if (dout_en) begin
        int a;
        a = addr;
        chk(dout, (a == 3) ? 8'hFF : (ch_rdata >> (8 * a)) & 8'hFF, "R9/R10 dout");
      end
    end
    if (cycles > 20000) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic bus_wr(int a, int d, int hold, bit sel = 1'b1);
    @(negedge clk);
    addr = 2'(a); din = 8'(d); cs_n = !sel; wr_n = 1'b0;
    repeat (hold) @(negedge clk);
    wr_n = 1'b1; cs_n = 1'b1; din = 8'h00;
    repeat (2) @(negedge clk);
  endtask

  task automatic bus_rd(int a, int hold, int exp_byte, bit sel = 1'b1);
    @(negedge clk);
    addr = 2'(a); cs_n = !sel; rd_n = 1'b0;
    #1;
    if (sel) chk(dout, exp_byte, "R9/R10 directed dout");
    else     chk(dout_en, 0, "R3 dout_en unselected");
    repeat (hold) @(negedge clk);
    rd_n = 1'b1; cs_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    int c0;
    repeat (3) @(negedge clk);
    chk({load_stb, ctrl_stb, cnt_latch_stb, sts_latch_stb, rd_stb}, 0, "R1 strobes in reset");
    chk({wr_byte, ctrl_rw, ctrl_mode, ctrl_bcd}, 0, "R1 fields in reset");
    rst_n = 1'b1;
    @(negedge clk);

    bus_wr(0, 8'h34, 1);
    c0 = cnt_ld;
    bus_wr(1, 8'hAA, 5);
    chk(cnt_ld - c0, 1, "R12 long write gives one load strobe");
    bus_wr(2, 8'h12, 2);
    chk(wr_byte, 8'h12, "R2 wr_byte held");

    bus_wr(3, 8'b00_11_011_0, 1);
    chk(ctrl_mode, 3, "R4 mode");
    chk(ctrl_rw, 3, "R4 rw");
    bus_wr(3, 8'b01_01_110_1, 2);
    chk(ctrl_mode, 2, "R5 mode 110 seen as 2");
    chk(ctrl_bcd, 1, "R4 bcd");
    bus_wr(3, 8'b10_10_111_0, 1);
    chk(ctrl_mode, 3, "R5 mode 111 seen as 3");
    bus_wr(3, 8'b00_01_101_1, 1);
    chk(ctrl_mode, 5, "R4 mode 5");

    c0 = cnt_lat;
    bus_wr(3, 8'b01_00_010_0, 3);
    chk(ctrl_mode, 5, "R6 latch keeps mode");
    chk(ctrl_rw, 1, "R6 latch keeps rw");
    chk(cnt_lat - c0, 1, "R6 one latch strobe");

    bus_wr(3, 8'b11_00_111_0, 1);
    bus_wr(3, 8'b11_10_001_0, 2);
    bus_wr(3, 8'b11_01_101_0, 1);
    bus_wr(3, 8'b11_11_111_0, 1);
    c0 = cnt_lat;
    bus_wr(3, 8'b11_00_111_1, 1);
    chk(cnt_lat - c0, 0, "R8 broadcast with bit0 set ignored");

    c0 = cnt_ld;
    bus_wr(0, 8'h77, 3, 1'b0);
    chk(cnt_ld - c0, 0, "R3 unselected write ignored");
    chk(wr_byte, 8'hFF & 8'b11_00_111_1, "R3 wr_byte unchanged");

    c0 = cnt_rd;
    bus_rd(0, 1, 8'hA1);
    bus_rd(1, 4, 8'h3C);
    chk(cnt_rd - c0, 2, "R11 R12 one byte-taken strobe per read");
    ch_rdata = 24'hC3_0F_E8;
    bus_rd(2, 2, 8'hC3);
    c0 = cnt_rd;
    bus_rd(3, 2, 8'hFF);
    chk(cnt_rd - c0, 0, "R10 idle address read has no strobe");
    bus_rd(1, 2, 0, 1'b0);
    chk(cnt_rd - c0, 0, "R3 unselected read has no strobe");

    bus_wr(2, 8'h5E, 1);
    bus_rd(0, 1, 8'hE8);
    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule